// File: doc/BRIEF.md
# UART Receive/Transmit FIFO Trigger and Line Status Logic

This block holds the two byte queues of a UART: one collects characters delivered by the receive shift register, the other buffers bytes written by the host until the transmit shift register can take them. Each queue is 16 bytes deep by default. Every received character is stored together with three error flags (parity, framing, break). These flags feed the line status byte presented to the host.

A control register enables the queues, clears either queue through self-clearing strobe bits, and selects the receive trigger level. An enable register gates the interrupts. The receive-data-available interrupt follows the fill level of the receive queue against the selected trigger, so it drops as soon as enough data has been read. With every interrupt enable cleared, the host polls the line status byte instead. Serial timing, baud generation and modem lines belong to neighbouring blocks.

Top module: `uart_fifo_status`

## Requirements
- R1: Each queue holds up to 16 bytes and returns them in arrival order. A receive character offered while the queue is full is dropped, unless a host read happens in the same cycle; in that case it is accepted.
- R2: With interrupt enable bit 0 set, `rx_irq` is high while the receive fill level is at or above the trigger level. The trigger level is selected by control bits 7:6: 00=1, 01=4, 10=8, 11=14.
- R3: `rx_irq` falls in the cycle after the read that takes the fill level below the trigger level.
- R4: `isr_rx_trig` rises and falls in the same cycles as `rx_irq`.
- R5: `lsr[0]` is high from the cycle after a character is accepted until the receive queue is empty.
- R6: `lsr[5]` is high exactly when the transmit queue is empty. `tx_load` is high when `tsr_ready` is high and the queue is not empty, and it presents the oldest byte on `tx_data`.
- R7: `lsr[6]` is high only when the transmit queue is empty and `tsr_idle` is high.
- R8: `lsr[2]`, `lsr[3]` and `lsr[4]` show the parity, framing and break flags of the oldest stored character. `lsr[7]` is high while any stored character carries an error flag.
- R9: A dropped receive character sets `lsr[1]`. A pulse on `lsr_rd` clears it. A drop in the same cycle as the clear pulse leaves it set.
- R10: With interrupt enable bits 3:0 all cleared, `rx_irq` stays low whatever the fill level.
- R11: Control bit 1 flushes the receive queue and bit 2 flushes the transmit queue. Neither bit is kept, so a later control write without them flushes nothing.
- R12: With control bit 0 cleared, each queue holds one byte and the trigger level is 1. A write that changes bit 0 flushes both queues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control value: [0] enable, [1] receive flush, [2] transmit flush, [7:6] trigger select |
| ier_we | input | 1 | Interrupt enable register write strobe |
| ier_wdata | input | 4 | Interrupt enables; bit 0 gates the receive interrupt |
| rx_char_valid | input | 1 | Receive shift register offers a character |
| rx_char_data | input | 8 | Received character |
| rx_char_perr | input | 1 | Parity error flag of the character |
| rx_char_ferr | input | 1 | Framing error flag of the character |
| rx_char_brk | input | 1 | Break flag of the character |
| rhr_rd | input | 1 | Host read of the receive holding register |
| rhr_data | output | 8 | Oldest received character |
| thr_we | input | 1 | Host write of the transmit holding register |
| thr_wdata | input | 8 | Byte to transmit |
| tsr_ready | input | 1 | Transmit shift register can accept a byte |
| tsr_idle | input | 1 | Transmit shift register has nothing left to send |
| tx_load | output | 1 | Byte handed to the transmit shift register this cycle |
| tx_data | output | 8 | Byte being handed over |
| lsr_rd | input | 1 | Host read of line status; clears the overrun bit |
| rx_irq | output | 1 | Receive-data-available interrupt |
| isr_rx_trig | output | 1 | Interrupt status bit for the receive trigger |
| lsr | output | 8 | Line status byte |

## Verification
Two pairs of events can fall in the same cycle. The first is a character arriving while the receive queue is full, together with a host read. The second is an overrun drop together with the status read that would clear the overrun bit. The bench fills the queue to 16 and then raises `rx_char_valid` with `rhr_rd` in one cycle: no overrun may appear, and the new byte must come out 16th in order. It then fills the queue again and raises `rx_char_valid` with `lsr_rd` in one cycle: `lsr[1]` must stay set, and it may clear only on a later read.

// File: rtl/ufs_pkg.sv
package ufs_pkg;
    localparam int DATA_W = 8;
    localparam int FLAG_W = 3;
    localparam int ENTRY_W = DATA_W + FLAG_W;

    typedef struct packed {
        logic brk;
        logic ferr;
        logic perr;
    } rx_flags_t;

    function automatic int unsigned trigger_bytes(input logic [1:0] sel);
        case (sel)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 14;
        endcase
    endfunction
endpackage

// File: rtl/ufs_byte_fifo.sv
module ufs_byte_fifo #(
    parameter int W = 8,
    parameter int DEPTH = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          cap_one,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          push_ok,
    output logic          pop_ok
);
    typedef struct packed {
        logic [AW-1:0] rd;
        logic [AW-1:0] wr;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [W-1:0] mem [DEPTH];
    logic full;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        empty   = (st_q.cnt == '0);
        full    = cap_one ? !empty : (st_q.cnt == CW'(DEPTH));
        pop_ok  = pop && !empty && !flush;
        push_ok = push && !flush && (!full || pop_ok);
        st_d    = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (push_ok) st_d.wr = ptr_next(st_q.wr);
            if (pop_ok)  st_d.rd = ptr_next(st_q.rd);
            case ({push_ok, pop_ok})
                2'b10:   st_d.cnt = st_q.cnt + CW'(1);
                2'b01:   st_d.cnt = st_q.cnt - CW'(1);
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[st_q.wr] <= wdata;
    end

    assign rdata = mem[st_q.rd];
    assign count = st_q.cnt;
endmodule

// File: rtl/ufs_rx_status.sv
module ufs_rx_status #(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push_ok,
    input  logic          push_err,
    input  logic          pop_ok,
    input  logic          pop_err,
    input  logic          drop_evt,
    input  logic          lsr_rd,
    input  logic [CW-1:0] level,
    input  logic [CW-1:0] trigger,
    input  logic          irq_en,
    output logic          rx_irq,
    output logic          overrun,
    output logic          err_any
);
    typedef struct packed {
        logic [CW-1:0] ecnt;
        logic          ovr;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.ecnt = '0;
        end else begin
            case ({push_ok && push_err, pop_ok && pop_err})
                2'b10:   st_d.ecnt = st_q.ecnt + CW'(1);
                2'b01:   st_d.ecnt = st_q.ecnt - CW'(1);
                default: st_d.ecnt = st_q.ecnt;
            endcase
        end
        if (drop_evt)    st_d.ovr = 1'b1;
        else if (lsr_rd) st_d.ovr = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_irq  = irq_en && (level != '0) && (level >= trigger);
    assign overrun = st_q.ovr;
    assign err_any = (st_q.ecnt != '0);
endmodule

// File: rtl/uart_fifo_status.sv
module uart_fifo_status
    import ufs_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_we,
    input  logic [7:0] ctrl_wdata,
    input  logic       ier_we,
    input  logic [3:0] ier_wdata,
    input  logic       rx_char_valid,
    input  logic [7:0] rx_char_data,
    input  logic       rx_char_perr,
    input  logic       rx_char_ferr,
    input  logic       rx_char_brk,
    input  logic       rhr_rd,
    output logic [7:0] rhr_data,
    input  logic       thr_we,
    input  logic [7:0] thr_wdata,
    input  logic       tsr_ready,
    input  logic       tsr_idle,
    output logic       tx_load,
    output logic [7:0] tx_data,
    input  logic       lsr_rd,
    output logic       rx_irq,
    output logic       isr_rx_trig,
    output logic [7:0] lsr
);
    typedef struct packed {
        logic       en;
        logic [1:0] tsel;
        logic [3:0] ier;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic rx_flush, tx_flush, en_change;
    logic [CW-1:0] trigger;

    always_comb begin
        ctl_d     = ctl_q;
        en_change = ctrl_we && (ctrl_wdata[0] != ctl_q.en);
        rx_flush  = ctrl_we && (ctrl_wdata[1] || en_change);
        tx_flush  = ctrl_we && (ctrl_wdata[2] || en_change);
        if (ctrl_we) begin
            ctl_d.en   = ctrl_wdata[0];
            ctl_d.tsel = ctrl_wdata[7:6];
        end
        if (ier_we) ctl_d.ier = ier_wdata;
        trigger = ctl_q.en ? CW'(trigger_bytes(ctl_q.tsel)) : CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    rx_flags_t in_flags, head_flags;
    logic [ENTRY_W-1:0] rx_head;
    logic [CW-1:0] rx_level, tx_level;
    logic rx_empty, rx_push_ok, rx_pop_ok;
    logic tx_empty, tx_push_ok, tx_pop_ok;
    logic overrun, err_any, irq_int;

    assign in_flags = '{brk: rx_char_brk, ferr: rx_char_ferr, perr: rx_char_perr};

    ufs_byte_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush), .cap_one(!ctl_q.en),
        .push(rx_char_valid), .wdata({in_flags, rx_char_data}), .pop(rhr_rd),
        .rdata(rx_head), .count(rx_level), .empty(rx_empty),
        .push_ok(rx_push_ok), .pop_ok(rx_pop_ok)
    );

    ufs_byte_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush), .cap_one(!ctl_q.en),
        .push(thr_we), .wdata(thr_wdata), .pop(tx_load),
        .rdata(tx_data), .count(tx_level), .empty(tx_empty),
        .push_ok(tx_push_ok), .pop_ok(tx_pop_ok)
    );

    assign head_flags = rx_empty ? '0 : rx_flags_t'(rx_head[ENTRY_W-1:DATA_W]);

    ufs_rx_status #(.DEPTH(DEPTH)) u_rx_status (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush),
        .push_ok(rx_push_ok), .push_err(|in_flags),
        .pop_ok(rx_pop_ok), .pop_err(|head_flags),
        .drop_evt(rx_char_valid && !rx_push_ok && !rx_flush),
        .lsr_rd(lsr_rd), .level(rx_level), .trigger(trigger),
        .irq_en(ctl_q.ier[0]), .rx_irq(irq_int),
        .overrun(overrun), .err_any(err_any)
    );

    assign tx_load     = tsr_ready && !tx_empty;
    assign rhr_data    = rx_head[DATA_W-1:0];
    assign rx_irq      = irq_int;
    assign isr_rx_trig = irq_int;
    assign lsr = {err_any, tx_empty && tsr_idle, tx_empty,
                  head_flags.brk, head_flags.ferr, head_flags.perr,
                  overrun, !rx_empty};
endmodule

// File: rtl/ufs_checker.sv
module ufs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_char_valid,
    input logic       rx_flush,
    input logic       lsr_rd,
    input logic       rx_irq,
    input logic       tx_load,
    input logic [7:0] lsr
);
    AST_IRQ_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> lsr[0]); // R2
    AST_DR_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        rx_char_valid && !rx_flush |=> lsr[0]); // R5
    AST_LOAD_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |-> !lsr[5]); // R6
    AST_TEMT_NEEDS_THRE: assert property (@(posedge clk) disable iff (!rst_n)
        lsr[6] |-> lsr[5]); // R7
    AST_ERR_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        lsr[7] |-> lsr[0]); // R8
    AST_OVR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        lsr_rd && !rx_char_valid |=> !lsr[1]); // R9
endmodule

bind uart_fifo_status ufs_checker u_chk (
    .clk(clk), .rst_n(rst_n), .rx_char_valid(rx_char_valid),
    .rx_flush(rx_flush), .lsr_rd(lsr_rd), .rx_irq(rx_irq),
    .tx_load(tx_load), .lsr(lsr)
);

// File: tb/tb_uart_fifo_status.sv
module tb_uart_fifo_status;
    logic clk = 0, rst_n = 0;
    logic ctrl_we = 0, ier_we = 0, rx_char_valid = 0, rhr_rd = 0, thr_we = 0;
    logic rx_char_perr = 0, rx_char_ferr = 0, rx_char_brk = 0;
    logic tsr_ready = 0, tsr_idle = 1, lsr_rd = 0;
    logic [7:0] ctrl_wdata = 0, rx_char_data = 0, thr_wdata = 0;
    logic [3:0] ier_wdata = 0;
    logic [7:0] rhr_data, tx_data, lsr;
    logic tx_load, rx_irq, isr_rx_trig;
    int checks = 0, fails = 0;
    bit done = 0;

    uart_fifo_status dut (.*);

    always #4 clk = ~clk;

    typedef struct packed {
        logic [1:0] sel;
        logic [4:0] n;
        logic       irq;
    } vec_t;
    localparam vec_t VECS [9] = '{
        '{2'd0, 5'd0, 1'b0}, '{2'd0, 5'd1, 1'b1}, '{2'd1, 5'd3, 1'b0},
        '{2'd1, 5'd4, 1'b1}, '{2'd2, 5'd7, 1'b0}, '{2'd2, 5'd8, 1'b1},
        '{2'd3, 5'd13, 1'b0}, '{2'd3, 5'd14, 1'b1}, '{2'd3, 5'd16, 1'b1}
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        ctrl_we = 1; ctrl_wdata = v; tick(); ctrl_we = 0;
    endtask

    task automatic wr_ier(input logic [3:0] v);
        ier_we = 1; ier_wdata = v; tick(); ier_we = 0;
    endtask

    task automatic push_rx(input logic [7:0] d, input logic [2:0] f);
        rx_char_valid = 1; rx_char_data = d;
        {rx_char_brk, rx_char_ferr, rx_char_perr} = f;
        tick();
        rx_char_valid = 0; {rx_char_brk, rx_char_ferr, rx_char_perr} = 3'b000;
    endtask

    task automatic read_rx(output logic [7:0] d);
        d = rhr_data; rhr_rd = 1; tick(); rhr_rd = 0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) tick();
        rst_n = 1;
        tick();
        check("R5 R6 R7 reset lsr", lsr, 8'h60);
        check("R2 reset irq", rx_irq, 0);

        wr_ier(4'h1);
        foreach (VECS[i]) begin
            wr_ctrl({VECS[i].sel, 3'b000, 3'b111});
            for (int k = 0; k < VECS[i].n; k++) push_rx(8'(k), 3'b000);
            check("R2 trigger irq", rx_irq, VECS[i].irq);
            check("R4 status mirrors", isr_rx_trig, VECS[i].irq);
            check("R5 data ready", lsr[0], VECS[i].n != 0);
        end

        // queue full with 0..15, trigger 14
        push_rx(8'hAA, 3'b000);
        check("R9 overrun set", lsr[1], 1);
        for (int k = 0; k < 16; k++) begin
            read_rx(d);
            check("R1 order", d, 8'(k));
            check("R3 irq follows level", rx_irq, (15 - k) >= 14);
        end
        check("R5 empty clears", lsr[0], 0);
        lsr_rd = 1; tick(); lsr_rd = 0;
        check("R9 overrun cleared", lsr[1], 0);

        // full plus simultaneous push and read
        for (int k = 0; k < 16; k++) push_rx(8'h10 + 8'(k), 3'b000);
        rx_char_valid = 1; rx_char_data = 8'hEE; d = rhr_data; rhr_rd = 1;
        tick(); rx_char_valid = 0; rhr_rd = 0;
        check("R1 head on full read", d, 8'h10);
        check("R1 no drop when read", lsr[1], 0);
        for (int k = 1; k < 16; k++) begin
            read_rx(d);
            check("R1 order after", d, 8'h10 + 8'(k));
        end
        read_rx(d);
        check("R1 last accepted", d, 8'hEE);
        check("R5 empty", lsr[0], 0);

        // drop and clear in same cycle
        for (int k = 0; k < 16; k++) push_rx(8'(k), 3'b000);
        lsr_rd = 1; push_rx(8'h55, 3'b000); lsr_rd = 0;
        check("R9 set wins", lsr[1], 1);
        lsr_rd = 1; tick(); lsr_rd = 0;
        check("R9 later clear", lsr[1], 0);
        wr_ctrl(8'hC3);
        check("R11 rx flush", lsr[0], 0);
        check("R3 irq after flush", rx_irq, 0);
        push_rx(8'h42, 3'b000);
        wr_ctrl(8'hC1);
        check("R11 strobe not kept", lsr[0], 1);
        read_rx(d);
        check("R11 data kept", d, 8'h42);

        // error flags
        push_rx(8'h01, 3'b000);
        push_rx(8'h02, 3'b001);
        check("R8 any error", lsr[7], 1);
        check("R8 head clean", lsr[4:2], 3'b000);
        read_rx(d);
        check("R8 head parity", lsr[4:2], 3'b001);
        push_rx(8'h03, 3'b110);
        read_rx(d);
        check("R8 head framing+break", lsr[4:2], 3'b110);
        check("R8 still error", lsr[7], 1);
        read_rx(d);
        check("R8 error gone", lsr[7], 0);
        check("R8 flags clear", lsr[4:2], 3'b000);

        // polled mode
        wr_ier(4'h0);
        for (int k = 0; k < 14; k++) push_rx(8'(k), 3'b000);
        check("R10 no irq", rx_irq, 0);
        check("R10 no status", isr_rx_trig, 0);
        check("R10 poll data ready", lsr[0], 1);
        wr_ier(4'h1);
        check("R2 enable raises irq", rx_irq, 1);
        wr_ctrl(8'hC3);

        // transmit side
        thr_we = 1; thr_wdata = 8'h5A; tick(); thr_wdata = 8'hA5; tick(); thr_we = 0;
        check("R6 not empty", lsr[5], 0);
        check("R7 not empty", lsr[6], 0);
        check("R6 no load", tx_load, 0);
        tsr_ready = 1; tsr_idle = 0; #1;
        check("R6 load first", {tx_load, tx_data}, {1'b1, 8'h5A});
        tick();
        check("R6 load second", {tx_load, tx_data}, {1'b1, 8'hA5});
        tick();
        check("R6 empty", {tx_load, lsr[5]}, 2'b01);
        check("R7 shifter busy", lsr[6], 0);
        tsr_idle = 1; #1;
        check("R7 all idle", lsr[6], 1);
        tsr_ready = 0;
        thr_we = 1; thr_wdata = 8'h77; tick(); thr_we = 0;
        wr_ctrl(8'hC5);
        check("R11 tx flush", lsr[5], 1);

        // queues disabled
        wr_ctrl(8'h00);
        push_rx(8'h77, 3'b000);
        check("R12 trigger one", rx_irq, 1);
        push_rx(8'h88, 3'b000);
        check("R12 capacity one", lsr[1], 1);
        read_rx(d);
        check("R12 kept first", d, 8'h77);
        check("R12 now empty", lsr[0], 0);
        push_rx(8'h99, 3'b000);
        wr_ctrl(8'h01);
        check("R12 enable flushes", lsr[0], 0);

        done = 1;
        summary();
    end
endmodule